// File: doc/BRIEF.md
# Parallel Multi-Stack Store

This block keeps a set of independent last-in-first-out stacks, by default eight of them, each 32 entries deep and 64 bits wide. Each stack also carries one base address register of the same width. A fixed number of access ports, two by default, each name a stack and an operation in every cycle. The available operations are push, pop, peek, push-only-if-empty, base read and base write. Read results come back combinationally in the same cycle and reflect the state before that cycle's updates. All updates take effect at the next rising clock edge.

Popping or peeking an empty stack returns zero and changes nothing. A plain push to a full stack is discarded and sets a sticky overflow flag for that stack. The top entry of every stack is always visible on a wide output bus, so condition logic and address arithmetic next to the block can use it without spending a port.

There is no sequencing state beyond the stack pointers. Every port request is resolved within the cycle by a fixed ordering rule per stack: the pops of all ports are taken first, and the pushes are then appended in ascending port order.

Top module: `multi_stack_bank`

## Requirements
- R1: Each stack is last-in-first-out. Values pushed on one stack come back from pops in reverse order, and other stacks are not disturbed.
- R2: A stack holds at most STACK_DEPTH entries. A plain push to a full stack is discarded, and it sets bit s of `ovf_o`, where s is the stack index. That bit stays set until reset.
- R3: A pop or a peek on an empty stack returns 0 on its port and leaves the stack empty.
- R4: A peek returns the current top entry and does not remove it.
- R5: A push-if-empty writes its value only when the stack holds no entries at the point where the request is applied. That point comes after this cycle's pops and after the pushes of lower-numbered ports. Otherwise the value is dropped and no flag is set.
- R6: Each stack has a base register. A base write stores the value at the clock edge. A base read returns the value held before this cycle's writes. When several ports write the same base in one cycle, the highest-numbered port wins.
- R7: After reset, every stack is empty, `ovf_o` is 0 and every base register is 0.
- R8: When several ports reach the same stack in one cycle, the pops in ascending port order receive the pre-cycle top, then the entry below it, and so on, with 0 once the entries run out. The pushes are then appended in ascending port order, so the highest-numbered pushing port ends on top.
- R9: `tos_o` slice s (bits s*DATA_W and up) shows the top entry of stack s, or 0 when it is empty. It follows the state after the last clock edge, without further delay.
- R10: Port operation codes are 0 none, 1 push, 2 pop, 3 peek, 4 push-if-empty, 5 base read, 6 base write and 7 none. Port p's field lies at bits p*3 of `op_i`. A port whose operation reads nothing returns 0 and changes no state, except for its own push or base write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | NUM_PORTS*3 | Operation code per port |
| sel_i | input | NUM_PORTS*SEL_W | Stack index per port |
| wdata_i | input | NUM_PORTS*DATA_W | Write value per port |
| rdata_o | output | NUM_PORTS*DATA_W | Read result per port, combinational |
| tos_o | output | NUM_STACKS*DATA_W | Top entry of every stack |
| ovf_o | output | NUM_STACKS | Sticky overflow flag per stack |

## Verification
The bench builds the block with four stacks that are four entries deep and 16 bits wide, and with two ports. At that depth, filling a stack, overflowing it and draining it past empty each take only a handful of cycles. It then sweeps every pairing of the two ports' operations and target stacks, 1024 combinations, followed by a long pseudo-random run. Every cycle is compared against an arithmetic model of the ordering rule, so same-stack collisions of every operation pair are covered, on both colliding and separate stacks.

// File: rtl/msk_pkg.sv
package msk_pkg;

    typedef enum logic [2:0] {
        MSK_NOP        = 3'd0,
        MSK_PUSH       = 3'd1,
        MSK_POP        = 3'd2,
        MSK_PEEK       = 3'd3,
        MSK_PUSH_EMPTY = 3'd4,
        MSK_BASE_RD    = 3'd5,
        MSK_BASE_WR    = 3'd6,
        MSK_IDLE       = 3'd7
    } msk_op_e;

    localparam int MSK_OP_W = 3;

endpackage

// File: rtl/msk_lane.sv
module msk_lane
    import msk_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int DEPTH     = 32,
    parameter int NUM_PORTS = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_PORTS-1:0][MSK_OP_W-1:0]    op_i,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]      wdata_i,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]      rdata_o,
    output logic [DATA_W-1:0]                     tos_o,
    output logic                                  ovf_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int KW = $clog2(DEPTH + NUM_PORTS + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CW-1:0]     sp_q, sp_d;
    logic [DATA_W-1:0] base_q, base_d;
    logic              ovf_q, ovf_d;
    logic [NUM_PORTS-1:0]         wr_en;
    logic [NUM_PORTS-1:0][AW-1:0] wr_ix;

    // Resolve all port requests on this stack: pops first, then pushes.
    always_comb begin
        logic [KW-1:0] npop;
        logic [KW-1:0] run;
        rdata_o = '0;
        wr_en   = '0;
        wr_ix   = '0;
        base_d  = base_q;
        ovf_d   = ovf_q;
        npop    = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            unique case (msk_op_e'(op_i[p]))
                MSK_POP: begin
                    if (KW'(sp_q) > npop)
                        rdata_o[p] = mem[AW'(KW'(sp_q) - npop - 1'b1)];
                    npop = npop + 1'b1;
                end
                MSK_PEEK: begin
                    if (sp_q != '0)
                        rdata_o[p] = mem[AW'(sp_q - 1'b1)];
                end
                MSK_BASE_RD: rdata_o[p] = base_q;
                default: ;
            endcase
        end
        run = (KW'(sp_q) > npop) ? (KW'(sp_q) - npop) : '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            unique case (msk_op_e'(op_i[p]))
                MSK_PUSH, MSK_PUSH_EMPTY: begin
                    if (msk_op_e'(op_i[p]) == MSK_PUSH || run == '0) begin
                        if (run < KW'(DEPTH)) begin
                            wr_en[p] = 1'b1;
                            wr_ix[p] = AW'(run);
                            run      = run + 1'b1;
                        end else begin
                            ovf_d = 1'b1;
                        end
                    end
                end
                MSK_BASE_WR: base_d = wdata_i[p];
                default: ;
            endcase
        end
        sp_d = CW'(run);
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (wr_en[p])
                mem[wr_ix[p]] <= wdata_i[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q   <= '0;
            base_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            sp_q   <= sp_d;
            base_q <= base_d;
            ovf_q  <= ovf_d;
        end
    end

    assign tos_o = (sp_q != '0) ? mem[AW'(sp_q - 1'b1)] : '0;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/msk_rd_merge.sv
module msk_rd_merge #(
    parameter int DATA_W    = 64,
    parameter int NUM_PORTS = 2,
    parameter int NUM_LANES = 8
) (
    input  logic [NUM_LANES-1:0][NUM_PORTS-1:0][DATA_W-1:0] lane_rd_i,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]                rd_o
);

    // Only the addressed lane drives a nonzero value for a port.
    always_comb begin
        rd_o = '0;
        for (int l = 0; l < NUM_LANES; l++)
            rd_o = rd_o | lane_rd_i[l];
    end

endmodule

// File: rtl/multi_stack_bank.sv
module multi_stack_bank
    import msk_pkg::*;
#(
    parameter int NUM_STACKS  = 8,
    parameter int STACK_DEPTH = 32,
    parameter int DATA_W      = 64,
    parameter int NUM_PORTS   = 2,
    localparam int SEL_W      = (NUM_STACKS > 1) ? $clog2(NUM_STACKS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PORTS*MSK_OP_W-1:0]   op_i,
    input  logic [NUM_PORTS*SEL_W-1:0]      sel_i,
    input  logic [NUM_PORTS*DATA_W-1:0]     wdata_i,
    output logic [NUM_PORTS*DATA_W-1:0]     rdata_o,
    output logic [NUM_STACKS*DATA_W-1:0]    tos_o,
    output logic [NUM_STACKS-1:0]           ovf_o
);

    logic [NUM_PORTS-1:0][MSK_OP_W-1:0]   port_op;
    logic [NUM_PORTS-1:0][SEL_W-1:0]      port_sel;
    logic [NUM_PORTS-1:0][DATA_W-1:0]     port_wd;
    logic [NUM_PORTS-1:0][DATA_W-1:0]     port_rd;
    logic [NUM_STACKS-1:0][NUM_PORTS-1:0][MSK_OP_W-1:0] lane_op;
    logic [NUM_STACKS-1:0][NUM_PORTS-1:0][DATA_W-1:0]   lane_rd;
    logic [NUM_STACKS-1:0][DATA_W-1:0]                  lane_tos;

    assign port_op  = op_i;
    assign port_sel = sel_i;
    assign port_wd  = wdata_i;

    for (genvar s = 0; s < NUM_STACKS; s++) begin : g_lane
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_steer
            assign lane_op[s][p] = (port_sel[p] == SEL_W'(s)) ? port_op[p] : MSK_NOP;
        end

        msk_lane #(
            .DATA_W   (DATA_W),
            .DEPTH    (STACK_DEPTH),
            .NUM_PORTS(NUM_PORTS)
        ) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .op_i   (lane_op[s]),
            .wdata_i(port_wd),
            .rdata_o(lane_rd[s]),
            .tos_o  (lane_tos[s]),
            .ovf_o  (ovf_o[s])
        );
    end

    msk_rd_merge #(
        .DATA_W   (DATA_W),
        .NUM_PORTS(NUM_PORTS),
        .NUM_LANES(NUM_STACKS)
    ) merge_i (
        .lane_rd_i(lane_rd),
        .rd_o     (port_rd)
    );

    assign rdata_o = port_rd;
    assign tos_o   = lane_tos;

endmodule

// File: rtl/msk_bank_chk.sv
module msk_bank_chk
    import msk_pkg::*;
#(
    parameter int NUM_STACKS  = 8,
    parameter int DATA_W      = 64,
    parameter int NUM_PORTS   = 2,
    parameter int SEL_W       = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_PORTS*MSK_OP_W-1:0] op_i,
    input logic [NUM_PORTS*SEL_W-1:0]    sel_i,
    input logic [NUM_PORTS*DATA_W-1:0]   wdata_i,
    input logic [NUM_PORTS*DATA_W-1:0]   rdata_o,
    input logic [NUM_STACKS*DATA_W-1:0]  tos_o,
    input logic [NUM_STACKS-1:0]         ovf_o
);

    localparam int LP = NUM_PORTS - 1;

    logic [NUM_STACKS-1:0][DATA_W-1:0] tos_a;
    logic [MSK_OP_W-1:0] op0, opl;
    logic [SEL_W-1:0]    sel0, sell;
    logic [DATA_W-1:0]   rd0, wdl;
    logic                any_push, seen_q, lpush_q;
    logic [SEL_W-1:0]    lsel_q;
    logic [DATA_W-1:0]   lwd_q;

    assign tos_a = tos_o;
    assign op0   = op_i[MSK_OP_W-1:0];
    assign sel0  = sel_i[SEL_W-1:0];
    assign rd0   = rdata_o[DATA_W-1:0];
    assign opl   = op_i[LP*MSK_OP_W +: MSK_OP_W];
    assign sell  = sel_i[LP*SEL_W +: SEL_W];
    assign wdl   = wdata_i[LP*DATA_W +: DATA_W];

    always_comb begin
        any_push = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (op_i[p*MSK_OP_W +: MSK_OP_W] == MSK_PUSH ||
                op_i[p*MSK_OP_W +: MSK_OP_W] == MSK_PUSH_EMPTY)
                any_push = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            lpush_q <= 1'b0;
            lsel_q  <= '0;
            lwd_q   <= '0;
        end else begin
            seen_q  <= 1'b1;
            lpush_q <= (opl == MSK_PUSH) && (int'(sell) < NUM_STACKS);
            lsel_q  <= sell;
            lwd_q   <= wdl;
        end
    end

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> (ovf_o == '0 && tos_o == '0));

    p_peek_is_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op0 == MSK_PEEK && int'(sel0) < NUM_STACKS) |-> rd0 == tos_a[sel0]);

    p_quiet_ops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op0 == MSK_NOP || op0 == MSK_IDLE || op0 == MSK_PUSH ||
         op0 == MSK_PUSH_EMPTY || op0 == MSK_BASE_WR) |-> rd0 == '0);

    p_ovf_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o != '0 |=> (ovf_o & $past(ovf_o)) == $past(ovf_o));

    p_ovf_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o & ~$past(ovf_o)) != '0 |-> $past(any_push));

    p_last_push_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lpush_q |-> (tos_a[lsel_q] == lwd_q || ovf_o[lsel_q]));

endmodule

bind multi_stack_bank msk_bank_chk #(
    .NUM_STACKS(NUM_STACKS),
    .DATA_W    (DATA_W),
    .NUM_PORTS (NUM_PORTS),
    .SEL_W     (SEL_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_i   (op_i),
    .sel_i  (sel_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .tos_o  (tos_o),
    .ovf_o  (ovf_o)
);

// File: tb/multi_stack_bank_tb_top.sv
module multi_stack_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int D  = 4;
    localparam int W  = 16;
    localparam int NP = 2;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP*3-1:0]  op_i = '0;
    logic [NP*SW-1:0] sel_i = '0;
    logic [NP*W-1:0]  wdata_i = '0;
    logic [NP*W-1:0]  rdata_o;
    logic [NS*W-1:0]  tos_o;
    logic [NS-1:0]    ovf_o;

    multi_stack_bank #(
        .NUM_STACKS(NS), .STACK_DEPTH(D), .DATA_W(W), .NUM_PORTS(NP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .sel_i(sel_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .tos_o(tos_o), .ovf_o(ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0] m_st [NS][D];
    int           m_sp [NS];
    logic [W-1:0] m_base [NS];
    logic [NS-1:0] m_ovf;
    logic [W-1:0] rd_seen [NP];
    logic [W-1:0] tos_seen [NS];
    logic [NS-1:0] ovf_seen;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cycle(string req,
                         logic [2:0] o0, logic [SW-1:0] s0, logic [W-1:0] w0,
                         logic [2:0] o1, logic [SW-1:0] s1, logic [W-1:0] w1);
        logic [2:0]    o [NP];
        logic [SW-1:0] s [NP];
        logic [W-1:0]  w [NP];
        logic [W-1:0]  erd [NP];
        o[0] = o0; o[1] = o1; s[0] = s0; s[1] = s1; w[0] = w0; w[1] = w1;
        @(negedge clk);
        op_i = {o1, o0}; sel_i = {s1, s0}; wdata_i = {w1, w0};
        #1;
        for (int k = 0; k < NS; k++) begin
            tos_seen[k] = tos_o[k*W +: W];
            check("R9", "tos", tos_seen[k], (m_sp[k] > 0) ? m_st[k][m_sp[k]-1] : '0);
        end
        ovf_seen = ovf_o;
        check("R2", "ovf", W'(ovf_seen), W'(m_ovf));
        for (int p = 0; p < NP; p++) erd[p] = '0;
        for (int k = 0; k < NS; k++) begin
            int npop;
            int run;
            npop = 0;
            for (int p = 0; p < NP; p++) if (int'(s[p]) == k) begin
                if (o[p] == 3'd2) begin
                    erd[p] = (m_sp[k] > npop) ? m_st[k][m_sp[k]-1-npop] : '0;
                    npop++;
                end else if (o[p] == 3'd3) begin
                    erd[p] = (m_sp[k] > 0) ? m_st[k][m_sp[k]-1] : '0;
                end else if (o[p] == 3'd5) begin
                    erd[p] = m_base[k];
                end
            end
            run = (m_sp[k] > npop) ? m_sp[k] - npop : 0;
            for (int p = 0; p < NP; p++) if (int'(s[p]) == k) begin
                if (o[p] == 3'd1 || (o[p] == 3'd4 && run == 0)) begin
                    if (run < D) begin m_st[k][run] = w[p]; run++; end
                    else m_ovf[k] = 1'b1;
                end else if (o[p] == 3'd6) begin
                    m_base[k] = w[p];
                end
            end
            m_sp[k] = run;
        end
        for (int p = 0; p < NP; p++) begin
            rd_seen[p] = rdata_o[p*W +: W];
            check(req, "rdata", rd_seen[p], erd[p]);
        end
    endtask

    task automatic idle();
        cycle("R10", 3'd0, 2'd0, '0, 3'd0, 2'd0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual expired expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int k = 0; k < NS; k++) begin
            m_sp[k] = 0; m_base[k] = '0;
            for (int j = 0; j < D; j++) m_st[k][j] = '0;
        end
        m_ovf = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state
        idle();
        for (int k = 0; k < NS; k++) check("R7", "tos after reset", tos_seen[k], '0);
        check("R7", "ovf after reset", W'(ovf_seen), '0);
        cycle("R7", 3'd5, 2'd2, '0, 3'd5, 2'd3, '0);
        check("R7", "base after reset", rd_seen[0], '0);

        // R1: LIFO order
        cycle("R1", 3'd1, 2'd2, 16'hA001, 3'd0, 2'd0, '0);
        cycle("R1", 3'd1, 2'd2, 16'hA002, 3'd0, 2'd0, '0);
        cycle("R1", 3'd2, 2'd2, '0, 3'd0, 2'd0, '0);
        check("R1", "first pop", rd_seen[0], 16'hA002);
        cycle("R1", 3'd2, 2'd2, '0, 3'd0, 2'd0, '0);
        check("R1", "second pop", rd_seen[0], 16'hA001);

        // R3: empty pop and peek
        cycle("R3", 3'd2, 2'd2, '0, 3'd3, 2'd2, '0);
        check("R3", "empty pop", rd_seen[0], '0);
        check("R3", "empty peek", rd_seen[1], '0);
        idle();
        check("R3", "still empty", tos_seen[2], '0);

        // R4: peek does not remove
        cycle("R4", 3'd1, 2'd0, 16'h0BEE, 3'd0, 2'd0, '0);
        cycle("R4", 3'd3, 2'd0, '0, 3'd0, 2'd0, '0);
        cycle("R4", 3'd3, 2'd0, '0, 3'd0, 2'd0, '0);
        check("R4", "second peek", rd_seen[0], 16'h0BEE);

        // R2: fill stack 1 then overflow
        for (int j = 0; j < D; j++) cycle("R2", 3'd1, 2'd1, 16'h0100 + 16'(j), 3'd0, 2'd0, '0);
        cycle("R2", 3'd1, 2'd1, 16'h01FF, 3'd0, 2'd0, '0);
        idle();
        check("R2", "ovf set", W'(ovf_seen), 16'h0002);
        check("R2", "full top kept", tos_seen[1], 16'h0103);
        cycle("R2", 3'd2, 2'd1, '0, 3'd0, 2'd0, '0);
        idle();
        check("R2", "ovf sticky", W'(ovf_seen), 16'h0002);

        // R5: push-if-empty
        cycle("R5", 3'd4, 2'd3, 16'h0033, 3'd0, 2'd0, '0);
        cycle("R5", 3'd4, 2'd3, 16'h0044, 3'd0, 2'd0, '0);
        idle();
        check("R5", "dropped on nonempty", tos_seen[3], 16'h0033);
        cycle("R5", 3'd2, 2'd3, '0, 3'd4, 2'd3, 16'h0055);
        check("R5", "pop same cycle", rd_seen[0], 16'h0033);
        idle();
        check("R5", "fires after pop", tos_seen[3], 16'h0055);

        // R8: same-stack ordering
        cycle("R8", 3'd1, 2'd0, 16'h0A01, 3'd1, 2'd0, 16'h0A02);
        idle();
        check("R8", "higher port on top", tos_seen[0], 16'h0A02);
        cycle("R8", 3'd2, 2'd0, '0, 3'd2, 2'd0, '0);
        check("R8", "port0 pop", rd_seen[0], 16'h0A02);
        check("R8", "port1 pop", rd_seen[1], 16'h0A01);
        idle();
        check("R8", "remaining top", tos_seen[0], 16'h0BEE);

        // R6: base registers
        cycle("R6", 3'd6, 2'd2, 16'h1234, 3'd6, 2'd2, 16'h5678);
        cycle("R6", 3'd5, 2'd2, '0, 3'd6, 2'd2, 16'h9ABC);
        check("R6", "higher write wins, pre-cycle read", rd_seen[0], 16'h5678);
        cycle("R6", 3'd5, 2'd2, '0, 3'd5, 2'd1, '0);
        check("R6", "new base", rd_seen[0], 16'h9ABC);
        check("R6", "other base", rd_seen[1], '0);

        // R10: idle code 7
        cycle("R10", 3'd7, 2'd0, 16'hFFFF, 3'd7, 2'd1, 16'hFFFF);
        check("R10", "idle rdata", rd_seen[0], '0);
        idle();
        check("R10", "idle no change", tos_seen[0], 16'h0BEE);

        // R9: peek in the cycle of a push sees pre-cycle state
        cycle("R9", 3'd1, 2'd0, 16'h0C0C, 3'd3, 2'd0, '0);
        check("R9", "peek pre-cycle", rd_seen[1], 16'h0BEE);

        // R8: exhaustive sweep of op and stack pairs
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int x = 0; x < NS; x++)
                    for (int y = 0; y < NS; y++)
                        cycle("R8", 3'(a), SW'(x), 16'(a*64 + x*16 + y),
                              3'(b), SW'(y), 16'(16'h8000 + b*64 + y*4 + x));

        // R1: pseudo-random run
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = lfsr;
            cycle("R1", r[2:0], r[4:3], 16'(i) ^ r, r[7:5], r[9:8], r ^ 16'h5A5A);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule